// File: doc/BRIEF.md
# Compare-Period Timer with Conversion Trigger

A 16-bit up-counting timer with a 16-bit compare register beside it. When the compare unit is in special-event mode and the timer is linked to it, a match between the count and the compare value returns the count to zero. The compare value then acts as a period, and the count runs from zero up to the compare value before it starts again. Each match also sends a one-cycle start pulse to an analog-to-digital converter, provided the converter's enable input is high.

Software reaches the block through a byte-wide register port. It can load the count, set the compare value, pick the count source (the internal clock enable or an external input with a synchroniser), pick a prescaler, and read or clear an overflow flag. The overflow flag sets when the count wraps from 0xFFFF. An enable bit gates the flag onto the interrupt output. A 16-bit access mode buffers the high byte, so that a 16-bit value can be read or written as one consistent whole.

Top module: `cmp_period_timer`

## Requirements
- R1: With control bit 3 (link) set, mode register bit 0 (special-event) set and the timer on, an increment that finds count equal to the compare value loads count with 0 instead of count+1.
- R2: A match raises `adc_start` for exactly the cycle after the match edge, and only if `adc_en` was high at that edge. When `adc_en` is low, the count is still cleared.
- R3: In period use, the count visits 0..compare and wraps. After N increments from zero, count = N mod (compare+1).
- R4: A bus write to the count in the same cycle as a match loads the written value, and the match's clear is dropped. The conversion pulse is still sent.
- R5: With control bit 1 (external source) and bit 2 (sync-off) both set, matches do not clear the count and send no pulse.
- R6: Control register (address 4): bit 7 = 16-bit access, bit 6 always reads 0, bits 5:4 = prescaler exponent, bit 3 = link, bit 2 = sync-off, bit 1 = external source, bit 0 = on.
- R7: An increment from 0xFFFF sets the flag at address 5 bit 0. `irq` = flag AND address 5 bit 1. Writing address 5 loads both bits.
- R8: The count advances once per 2^p source pulses, where p is bits 5:4. The prescale counter clears on any load of the count.
- R9: In 16-bit mode, a write to address 1 goes to a buffer, and the next write to address 0 loads {buffer, data}. A read of address 0 latches count[15:8], and address 1 then returns that latched byte. In 8-bit mode, addresses 0 and 1 read and write the live bytes directly.
- R10: With the on bit clear, the count holds, and no match or pulse occurs.
- R11: In external mode, each rising edge of `ext_cnt` counts one source pulse after a two-stage synchroniser.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (drives read-side latching) |
| bus_addr | input | 3 | Register address: 0 count low, 1 count high, 2 compare low, 3 compare high, 4 control, 5 interrupt, 6 mode |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| tick_int | input | 1 | Internal count enable, one pulse per count |
| ext_cnt | input | 1 | External count input |
| adc_en | input | 1 | Converter enabled; gates the start pulse |
| count | output | 16 | Current timer value |
| irq | output | 1 | Overflow interrupt |
| adc_start | output | 1 | One-cycle conversion start pulse |

## Verification
A table of runs varies the compare value, the prescaler exponent, the link bit and the converter enable. The final count and the number of start pulses in each run separate a free-running count from wrapping at the period and show whether the prescaler divides correctly. A compare value of zero, where every increment matches, catches off-by-one errors in the wrap. Directed runs cover the following:
- A count write that lands on a match, which separates write priority from clear priority.
- The same external pulse train run synchronised and unsynchronised, which shows whether the reset is suppressed.
- A prescaler interrupted by a load, which exposes a prescale counter that is not cleared.
- Split byte accesses, which tell buffered transfers from live ones.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam logic [2:0] A_CNT_LO = 3'd0;
  localparam logic [2:0] A_CNT_HI = 3'd1;
  localparam logic [2:0] A_CMP_LO = 3'd2;
  localparam logic [2:0] A_CMP_HI = 3'd3;
  localparam logic [2:0] A_CTL    = 3'd4;
  localparam logic [2:0] A_IRQ    = 3'd5;
  localparam logic [2:0] A_MODE   = 3'd6;

  typedef struct packed {
    logic       wide;     // 16-bit buffered access
    logic       rsvd;     // always 0
    logic [1:0] ps;       // prescaler exponent
    logic       link;     // timer feeds compare unit
    logic       nosync;   // external input not synchronised
    logic       ext;      // external count source
    logic       on;       // timer running
  } tctl_t;

  localparam logic [7:0] CTL_WMASK = 8'hBF;

  // period-clear is allowed except for unsynchronised external counting
  function automatic logic reset_allowed(input tctl_t c);
    return !(c.ext && c.nosync);
  endfunction
endpackage

// File: rtl/tmr_ext_sync.sv
module tmr_ext_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES-1:0] sh_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      last_q <= 1'b0;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], din};
      last_q <= sh_q[STAGES-1];
    end
  end

  assign rise = sh_q[STAGES-1] && !last_q;
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pulse_in,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  output logic             pulse_out
);
  localparam int PRE_W = (1 << SEL_W) - 1;

  logic [PRE_W-1:0] pre_q;

  function automatic logic [PRE_W-1:0] top_of(input logic [SEL_W-1:0] s);
    return PRE_W'((1 << s) - 1);
  endfunction

  logic hit;
  assign hit       = pre_q >= top_of(sel);
  assign pulse_out = pulse_in && hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pre_q <= '0;
    else if (clr)      pre_q <= '0;
    else if (pulse_in) pre_q <= hit ? '0 : pre_q + 1'b1;
  end

  AST_PRESC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> pre_q == '0); // R8
endmodule

// File: rtl/tmr_match.sv
module tmr_match #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         arm,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] period,
  input  logic         adc_en,
  output logic         hit,
  output logic         trig
);
  assign hit = inc && arm && (cnt == period);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig <= 1'b0;
    else        trig <= hit && adc_en;
  end

  AST_TRIG_NEEDS_ADC: assert property (@(posedge clk) disable iff (!rst_n)
    trig |-> $past(adc_en) && $past(arm)); // R2
endmodule

// File: rtl/cmp_period_timer.sv
module cmp_period_timer
  import tmr_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [2:0]          bus_addr,
  input  logic [BYTE_W-1:0]   bus_wdata,
  output logic [BYTE_W-1:0]   bus_rdata,
  input  logic                tick_int,
  input  logic                ext_cnt,
  input  logic                adc_en,
  output logic [2*BYTE_W-1:0] count,
  output logic                irq,
  output logic                adc_start
);
  localparam int CW = 2 * BYTE_W;

  tctl_t             ctl_q;
  logic [CW-1:0]     cnt_q, cmp_q;
  logic [BYTE_W-1:0] hi_wbuf_q, hi_rbuf_q;
  logic              flag_q, irq_en_q, sev_q;

  // bus decode
  logic wr_lo, wr_hi, tmr_load;
  logic [CW-1:0] load_val;
  assign wr_lo    = bus_wr && bus_addr == A_CNT_LO;
  assign wr_hi    = bus_wr && bus_addr == A_CNT_HI;
  assign tmr_load = wr_lo || (wr_hi && !ctl_q.wide);

  always_comb begin
    if (wr_lo) load_val = ctl_q.wide ? {hi_wbuf_q, bus_wdata}
                                     : {cnt_q[CW-1:BYTE_W], bus_wdata};
    else       load_val = {bus_wdata, cnt_q[BYTE_W-1:0]};
  end

  // count source
  logic ext_rise, src_pulse, inc_evt, match_evt, ovf_evt, arm;

  tmr_ext_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(ext_cnt), .rise(ext_rise));

  assign src_pulse = ctl_q.on && (ctl_q.ext ? ext_rise : tick_int);

  tmr_prescale #(.SEL_W(2)) u_pre (
    .clk(clk), .rst_n(rst_n), .pulse_in(src_pulse), .clr(tmr_load),
    .sel(ctl_q.ps), .pulse_out(inc_evt));

  assign arm = ctl_q.link && sev_q && reset_allowed(ctl_q);

  tmr_match #(.W(CW)) u_match (
    .clk(clk), .rst_n(rst_n), .inc(inc_evt), .arm(arm), .cnt(cnt_q),
    .period(cmp_q), .adc_en(adc_en), .hit(match_evt), .trig(adc_start));

  assign ovf_evt = inc_evt && (&cnt_q) && !tmr_load;

  // counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (tmr_load)  cnt_q <= load_val;
    else if (match_evt) cnt_q <= '0;
    else if (inc_evt)   cnt_q <= cnt_q + 1'b1;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q     <= '0;
      cmp_q     <= '0;
      hi_wbuf_q <= '0;
      hi_rbuf_q <= '0;
      flag_q    <= 1'b0;
      irq_en_q  <= 1'b0;
      sev_q     <= 1'b0;
    end else begin
      if (bus_wr) begin
        case (bus_addr)
          A_CMP_LO: cmp_q[BYTE_W-1:0]  <= bus_wdata;
          A_CMP_HI: cmp_q[CW-1:BYTE_W] <= bus_wdata;
          A_CTL:    ctl_q <= tctl_t'(bus_wdata[7:0] & CTL_WMASK);
          A_IRQ:    irq_en_q <= bus_wdata[1];
          A_MODE:   sev_q <= bus_wdata[0];
          default:  ;
        endcase
      end
      if (wr_hi && ctl_q.wide) hi_wbuf_q <= bus_wdata;
      if (bus_rd && bus_addr == A_CNT_LO && ctl_q.wide)
        hi_rbuf_q <= cnt_q[CW-1:BYTE_W];
      if (ovf_evt)                          flag_q <= 1'b1;
      else if (bus_wr && bus_addr == A_IRQ) flag_q <= bus_wdata[0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CNT_LO: bus_rdata = cnt_q[BYTE_W-1:0];
      A_CNT_HI: bus_rdata = ctl_q.wide ? hi_rbuf_q : cnt_q[CW-1:BYTE_W];
      A_CMP_LO: bus_rdata = cmp_q[BYTE_W-1:0];
      A_CMP_HI: bus_rdata = cmp_q[CW-1:BYTE_W];
      A_CTL:    bus_rdata = BYTE_W'(ctl_q);
      A_IRQ:    bus_rdata = BYTE_W'({irq_en_q, flag_q});
      A_MODE:   bus_rdata = BYTE_W'(sev_q);
      default:  bus_rdata = '0;
    endcase
  end

  assign count = cnt_q;
  assign irq   = flag_q && irq_en_q;

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_load |=> cnt_q == $past(load_val)); // R4
  AST_MATCH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && !tmr_load) |=> cnt_q == '0); // R1
  AST_OVF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> flag_q); // R7
  AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q.on && !tmr_load) |=> $stable(cnt_q)); // R10
  AST_NO_UNSYNC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.ext && ctl_q.nosync) |-> !match_evt); // R5
endmodule

// File: tb/sim_cmp_period_timer.sv
module sim_cmp_period_timer;
  localparam int T_CLK = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0, bus_rdata;
  logic        tick_int = 1'b1, ext_cnt = 1'b0, adc_en = 1'b1;
  logic [15:0] count;
  logic        irq, adc_start;

  int n_chk = 0, n_bad = 0, n_trig = 0;

  cmp_period_timer u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_int(tick_int), .ext_cnt(ext_cnt), .adc_en(adc_en),
    .count(count), .irq(irq), .adc_start(adc_start));

  always #(T_CLK/2) clk = ~clk;
  always @(negedge clk) if (adc_start) n_trig++;

  typedef struct packed {
    logic [15:0] cmp;
    logic [1:0]  ps;
    logic        link;
    logic        adc;
    logic [7:0]  n;
    logic [15:0] exp;
    logic [7:0]  ntrig;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{16'd100, 2'd0, 1'b1, 1'b1, 8'd10, 16'd10, 8'd0},
    '{16'd5,   2'd0, 1'b1, 1'b1, 8'd10, 16'd4,  8'd1},
    '{16'd5,   2'd1, 1'b1, 1'b1, 8'd10, 16'd5,  8'd0},
    '{16'd5,   2'd2, 1'b1, 1'b1, 8'd30, 16'd1,  8'd1},
    '{16'd3,   2'd3, 1'b1, 1'b1, 8'd40, 16'd1,  8'd1},
    '{16'd0,   2'd0, 1'b1, 1'b1, 8'd7,  16'd0,  8'd7},
    '{16'd5,   2'd0, 1'b0, 1'b1, 8'd10, 16'd10, 8'd0},
    '{16'd2,   2'd0, 1'b1, 1'b0, 8'd6,  16'd0,  8'd0}
  };

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // called at a negedge; the write lands on the following posedge
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic setup(input logic [15:0] cmp, input logic [7:0] ctl_off);
    wr(3'd4, ctl_off);
    wr(3'd2, cmp[7:0]);
    wr(3'd3, cmp[15:8]);
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h00);
  endtask

  task automatic ext_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      ext_cnt = 1'b1; repeat (3) @(negedge clk);
      ext_cnt = 1'b0; repeat (3) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(T_CLK * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] rv;
    int t0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    check("reset count", count, 0);
    check("reset irq R7", irq, 0);
    check("reset adc_start R2", adc_start, 0);
    rd(3'd4, rv); check("reset ctl R6", rv, 0);

    // R6 control layout, bit 6 reads 0
    wr(3'd4, 8'hFE); rd(3'd4, rv); check("R6 ctl readback", rv, 8'hBE);
    wr(3'd4, 8'h00);

    wr(3'd6, 8'h01); // special-event mode

    // table: R1 R2 R3 R8
    for (int k = 0; k < 8; k++) begin
      logic [7:0] cbase;
      cbase = {2'b00, VEC[k].ps, VEC[k].link, 3'b000};
      adc_en = VEC[k].adc;
      setup(VEC[k].cmp, cbase);
      t0 = n_trig;
      wr(3'd4, cbase | 8'h01);
      repeat (int'(VEC[k].n) - 1) @(negedge clk);
      wr(3'd4, cbase);
      repeat (2) @(negedge clk);
      check($sformatf("R3 R8 vec%0d count", k), count, VEC[k].exp);
      check($sformatf("R1 R2 vec%0d pulses", k), n_trig - t0, VEC[k].ntrig);
    end
    adc_en = 1'b1;

    // R4 write coincides with match
    setup(16'd3, 8'h08);
    t0 = n_trig;
    wr(3'd4, 8'h09);
    repeat (3) @(negedge clk);
    wr(3'd0, 8'h40);
    check("R4 write beats clear", count, 16'h0040);
    wr(3'd4, 8'h08);
    repeat (2) @(negedge clk);
    check("R4 pulse still issued", n_trig - t0, 1);

    // R5 R11 unsynchronised external: no clear
    setup(16'd2, 8'h0E);
    t0 = n_trig;
    wr(3'd4, 8'h0F);
    ext_pulses(5);
    wr(3'd4, 8'h0E);
    check("R5 R11 unsync count", count, 5);
    check("R5 unsync no pulse", n_trig - t0, 0);

    // R11 synchronised external: wraps at period
    setup(16'd2, 8'h0A);
    t0 = n_trig;
    wr(3'd4, 8'h0B);
    ext_pulses(5);
    wr(3'd4, 8'h0A);
    check("R11 R1 sync count", count, 2);
    check("R11 sync pulses", n_trig - t0, 1);

    // R7 overflow flag and gating
    wr(3'd4, 8'h00);
    wr(3'd1, 8'hFF);
    wr(3'd0, 8'hFE);
    wr(3'd5, 8'h00);
    wr(3'd4, 8'h01);
    @(negedge clk);
    wr(3'd4, 8'h00);
    check("R7 wrapped count", count, 0);
    check("R7 irq gated off", irq, 0);
    rd(3'd5, rv); check("R7 flag set", rv, 8'h01);
    wr(3'd5, 8'h03); check("R7 irq enabled", irq, 1);
    wr(3'd5, 8'h02); check("R7 irq cleared", irq, 0);
    rd(3'd5, rv); check("R7 flag cleared", rv, 8'h02);
    wr(3'd5, 8'h00);

    // R8 prescaler cleared by timer load
    setup(16'd0, 8'h30);
    wr(3'd4, 8'h31);
    repeat (4) @(negedge clk);
    wr(3'd0, 8'h00);
    repeat (6) @(negedge clk);
    wr(3'd4, 8'h30);
    check("R8 seven after clear", count, 0);
    wr(3'd4, 8'h31);
    wr(3'd4, 8'h30);
    check("R8 eighth pulse", count, 1);

    // R9 16-bit buffered access
    wr(3'd4, 8'h80);
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h12);
    check("R9 high write buffered", count, 0);
    wr(3'd0, 8'h34);
    check("R9 paired load", count, 16'h1234);
    rd(3'd0, rv); check("R9 low read", rv, 8'h34);
    wr(3'd1, 8'h56);
    wr(3'd0, 8'h78);
    check("R9 second load", count, 16'h5678);
    rd(3'd1, rv); check("R9 latched high", rv, 8'h12);
    wr(3'd4, 8'h00);
    rd(3'd1, rv); check("R9 live high 8-bit", rv, 8'h56);

    // R10 timer off holds, no match
    setup(16'd0, 8'h08);
    wr(3'd0, 8'h05);
    t0 = n_trig;
    repeat (10) @(negedge clk);
    check("R10 off holds", count, 5);
    check("R10 off no pulse", n_trig - t0, 0);

    summary();
    $finish;
  end
endmodule